// File: doc/BRIEF.md
# Peripheral Register Address Router

This block is the register-access front end of a multi-function I/O controller. A bus master presents one access at a time. Each access carries a 19-bit byte offset, an access size, a direction and write data. The router finds the region that the offset falls in and picks one of ten downstream peripheral ports. For that port it extracts the register index from the offset bits that the peripheral expects. It also forwards the write data, byte-swapped where the port needs it.

Read data from the selected port is captured and returned to the master one cycle after the request. Accesses to unmapped regions read zero, are otherwise dropped, and raise a one-cycle warning pulse.

Two regions get special handling:
- The serial controller has a second, legacy address window. Offsets low in that window are remapped through a small table. Offsets in a dead gap above them read zero and raise an error pulse. Offsets above the gap fall through to native serial addressing.
- The DMA register window is decoded by channel. Channels the controller does not implement read zero, and writes to them are dropped. A first-access flag is kept for each such channel, separately for reads and for writes, and each flag stays set until reset.

Top module: `io_addr_router`

## Requirements
- R1: The region is offset[18:12]. At most one bit of `port_sel` is high, and only while `req_valid` is high. The bit positions are 0 control, 1 DMA, 2 SCSI, 3 Ethernet, 4 serial, 5 floppy, 6 VIA, 7 disk 0, 8 disk 1, 9 NVRAM. Region 0x00 selects control with index offset[7:0]. Regions 0x10, 0x13 and 0x15 select SCSI, serial and floppy with index offset[7:4].
- R2: Region 0x08 is the DMA window. The channel is offset[14:8] and the register is offset[7:0]. A channel whose bit is set in `DMA_MASK` selects the DMA port with index offset[14:0]. The default mask sets channels 0, 1, 2, 3, 7, 8, 11 and 12.
- R3: An access to a DMA channel whose mask bit is clear selects no port, and a read of it returns 0.
- R4: Each DMA channel missing from the mask has a read flag in `dma_rd_seen` and a write flag in `dma_wr_seen`. A flag is set by the first read or write to that channel and is cleared only by reset.
- R5: In region 0x12, when offset[7:0] < 0x0C, the serial port is selected. The index is a table lookup on k = offset[4:1]: k0→1, k1→3, k2→0, k3→2, k4→6, k5→4, and 0xF for every other k.
- R6: In region 0x12, when offset[7:0] is 0x0C to 0x5F, no port is selected, a read returns 0, and `err_pulse` is high in the response cycle.
- R7: In region 0x12, when offset[7:0] ≥ 0x60, the access is treated as a native serial access with index offset[7:4].
- R8: Regions 0x16 and 0x17 both select the VIA port with index offset[12:9].
- R9: Regions 0x20 and 0x21 select disk 0 and disk 1 with index offset[11:4]. When `DISK1_PRESENT` is 0, region 0x21 selects nothing and reads 0.
- R10: Region 0x11 selects Ethernet with index offset[11:0]. Data is swapped in both directions by size code: 0 (byte) leaves it unchanged, 1 (half) gives {16'h0, d[7:0], d[15:8]}, and 2 or 3 (word) gives a full 32-bit byte reverse.
- R11: Regions 0x60 to 0x7F select the NVRAM with byte index offset[16:4].
- R12: Every other region selects nothing, reads 0, and raises `warn_pulse` in the response cycle.
- R13: `req_ready` is always high. Every accepted request gives `rsp_valid` exactly one cycle later. The response to a write carries `rsp_rdata` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted (always 1) |
| req_write | input | 1 | 1 = write, 0 = read |
| req_offset | input | 19 | Byte offset within the controller |
| req_size | input | 2 | Size code: 0 byte, 1 half, 2/3 word |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Response present |
| rsp_rdata | output | 32 | Read data (0 for writes) |
| port_sel | output | 10 | One-hot peripheral select |
| port_we | output | 1 | Write strobe for the selected port |
| port_idx | output | 15 | Register index for the selected port |
| port_wdata | output | 32 | Write data to the port, swapped for Ethernet |
| port_rdata | input | 320 | Read data of all ports, port p in bits [32p+31:32p] |
| err_pulse | output | 1 | Serial alias gap was accessed |
| warn_pulse | output | 1 | Unmapped region was accessed |
| dma_rd_seen | output | 128 | Sticky read flags of unimplemented DMA channels |
| dma_wr_seen | output | 128 | Sticky write flags of unimplemented DMA channels |

## Verification
A wrong decode shows at once. `port_sel`, `port_idx` and `port_wdata` are combinational, so a bad route is visible in the same cycle as the request. A wrong read steering or swap shows on `rsp_rdata` exactly one cycle later. The bench's peripheral model encodes the port number and index into each word it returns, so misrouting cannot hide behind a matching value. A sticky flag that sets on the wrong channel, fails to set, or drops shows on the flag outputs at the next clock edge.

// File: rtl/io_rt_pkg.sv
package io_rt_pkg;
    localparam int OFF_W    = 19;
    localparam int DATA_W   = 32;
    localparam int IDX_W    = 15;
    localparam int NPORT    = 10;
    localparam int RG_W     = 7;
    localparam int DMA_CH_W = 7;
    localparam int NDMA     = 1 << DMA_CH_W;

    typedef enum logic [3:0] {
        P_CTRL  = 4'd0, P_DMA   = 4'd1, P_SCSI  = 4'd2, P_ENET  = 4'd3,
        P_SER   = 4'd4, P_FLOP  = 4'd5, P_VIA   = 4'd6, P_DISK0 = 4'd7,
        P_DISK1 = 4'd8, P_NVRAM = 4'd9
    } port_e;

    localparam logic [RG_W-1:0] RG_CTRL   = 7'h00;
    localparam logic [RG_W-1:0] RG_DMA    = 7'h08;
    localparam logic [RG_W-1:0] RG_SCSI   = 7'h10;
    localparam logic [RG_W-1:0] RG_ENET   = 7'h11;
    localparam logic [RG_W-1:0] RG_SERLEG = 7'h12;
    localparam logic [RG_W-1:0] RG_SER    = 7'h13;
    localparam logic [RG_W-1:0] RG_FLOP   = 7'h15;
    localparam logic [RG_W-1:0] RG_VIA_A  = 7'h16;
    localparam logic [RG_W-1:0] RG_VIA_B  = 7'h17;
    localparam logic [RG_W-1:0] RG_DISK0  = 7'h20;
    localparam logic [RG_W-1:0] RG_DISK1  = 7'h21;
    localparam logic [RG_W-1:0] RG_NVRAM  = 7'h60;

    localparam logic [7:0] LEG_TABLE_END = 8'h0C;
    localparam logic [7:0] LEG_GAP_END   = 8'h60;

    typedef struct packed {
        logic                hit;
        port_e               port;
        logic [IDX_W-1:0]    idx;
        logic                swap;
        logic                gap;
        logic                stray;
        logic                dma_bad;
        logic [DMA_CH_W-1:0] dma_ch;
    } route_t;

    function automatic logic [DATA_W-1:0] swap_by_size(logic [DATA_W-1:0] d, logic [1:0] sz);
        case (sz)
            2'd0:    return d;
            2'd1:    return {16'h0, d[7:0], d[15:8]};
            default: return {d[7:0], d[15:8], d[23:16], d[31:24]};
        endcase
    endfunction

    function automatic logic [3:0] legacy_map(logic [3:0] k);
        case (k)
            4'd0:    return 4'h1;
            4'd1:    return 4'h3;
            4'd2:    return 4'h0;
            4'd3:    return 4'h2;
            4'd4:    return 4'h6;
            4'd5:    return 4'h4;
            default: return 4'hF;
        endcase
    endfunction
endpackage

// File: rtl/io_rt_decode.sv
module io_rt_decode import io_rt_pkg::*; #(
    parameter bit              DISK1_PRESENT = 1'b1,
    parameter logic [NDMA-1:0] DMA_MASK      = 128'h198F
) (
    input  logic [OFF_W-1:0] off,
    output route_t           rt
);
    logic [RG_W-1:0] rg;
    logic [7:0]      low;

    assign rg  = off[18:12];
    assign low = off[7:0];

    always_comb begin
        rt        = '0;
        rt.port   = P_CTRL;
        rt.dma_ch = off[14:8];
        case (rg)
            RG_CTRL: begin
                rt.hit = 1'b1; rt.port = P_CTRL; rt.idx = IDX_W'(off[7:0]);
            end
            RG_DMA: begin
                if (DMA_MASK[off[14:8]]) begin
                    rt.hit = 1'b1; rt.port = P_DMA; rt.idx = off[14:0];
                end else begin
                    rt.dma_bad = 1'b1;
                end
            end
            RG_SCSI: begin
                rt.hit = 1'b1; rt.port = P_SCSI; rt.idx = IDX_W'(off[7:4]);
            end
            RG_ENET: begin
                rt.hit = 1'b1; rt.port = P_ENET; rt.idx = IDX_W'(off[11:0]); rt.swap = 1'b1;
            end
            RG_SERLEG: begin
                if (low < LEG_TABLE_END) begin
                    rt.hit = 1'b1; rt.port = P_SER; rt.idx = IDX_W'(legacy_map(off[4:1]));
                end else if (low < LEG_GAP_END) begin
                    rt.gap = 1'b1;
                end else begin
                    rt.hit = 1'b1; rt.port = P_SER; rt.idx = IDX_W'(off[7:4]);
                end
            end
            RG_SER: begin
                rt.hit = 1'b1; rt.port = P_SER; rt.idx = IDX_W'(off[7:4]);
            end
            RG_FLOP: begin
                rt.hit = 1'b1; rt.port = P_FLOP; rt.idx = IDX_W'(off[7:4]);
            end
            RG_VIA_A, RG_VIA_B: begin
                rt.hit = 1'b1; rt.port = P_VIA; rt.idx = IDX_W'(off[12:9]);
            end
            RG_DISK0: begin
                rt.hit = 1'b1; rt.port = P_DISK0; rt.idx = IDX_W'(off[11:4]);
            end
            RG_DISK1: begin
                rt.hit = DISK1_PRESENT; rt.port = P_DISK1; rt.idx = IDX_W'(off[11:4]);
            end
            default: begin
                if (rg >= RG_NVRAM) begin
                    rt.hit = 1'b1; rt.port = P_NVRAM; rt.idx = IDX_W'(off[16:4]);
                end else begin
                    rt.stray = 1'b1;
                end
            end
        endcase
    end
endmodule

// File: rtl/io_rt_dma_flags.sv
module io_rt_dma_flags import io_rt_pkg::*; (
    input  logic                clk,
    input  logic                rst,
    input  logic                rd_bad,
    input  logic                wr_bad,
    input  logic [DMA_CH_W-1:0] ch,
    output logic [NDMA-1:0]     rd_seen,
    output logic [NDMA-1:0]     wr_seen
);
    for (genvar i = 0; i < NDMA; i++) begin : g_ch
        logic hit;
        assign hit = (ch == DMA_CH_W'(i));
        always_ff @(posedge clk) begin
            if (rst) begin
                rd_seen[i] <= 1'b0;
                wr_seen[i] <= 1'b0;
            end else begin
                if (rd_bad && hit) rd_seen[i] <= 1'b1;
                if (wr_bad && hit) wr_seen[i] <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/io_rt_resp.sv
module io_rt_resp import io_rt_pkg::*; (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    fire,
    input  logic                    is_write,
    input  logic [1:0]              size,
    input  route_t                  rt,
    input  logic [NPORT*DATA_W-1:0] port_rdata,
    output logic                    rsp_valid,
    output logic [DATA_W-1:0]       rsp_rdata,
    output logic                    err_pulse,
    output logic                    warn_pulse
);
    logic [DATA_W-1:0] picked;
    logic [DATA_W-1:0] shaped;

    assign picked = port_rdata[int'(rt.port)*DATA_W +: DATA_W];
    assign shaped = rt.swap ? swap_by_size(picked, size) : picked;

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid  <= 1'b0;
            rsp_rdata  <= '0;
            err_pulse  <= 1'b0;
            warn_pulse <= 1'b0;
        end else begin
            rsp_valid  <= fire;
            err_pulse  <= fire && rt.gap;
            warn_pulse <= fire && rt.stray;
            rsp_rdata  <= (fire && !is_write && rt.hit) ? shaped : '0;
        end
    end
endmodule

// File: rtl/io_addr_router.sv
module io_addr_router import io_rt_pkg::*; #(
    parameter bit              DISK1_PRESENT = 1'b1,
    parameter logic [NDMA-1:0] DMA_MASK      = 128'h198F
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    req_valid,
    output logic                    req_ready,
    input  logic                    req_write,
    input  logic [OFF_W-1:0]        req_offset,
    input  logic [1:0]              req_size,
    input  logic [DATA_W-1:0]       req_wdata,
    output logic                    rsp_valid,
    output logic [DATA_W-1:0]       rsp_rdata,
    output logic [NPORT-1:0]        port_sel,
    output logic                    port_we,
    output logic [IDX_W-1:0]        port_idx,
    output logic [DATA_W-1:0]       port_wdata,
    input  logic [NPORT*DATA_W-1:0] port_rdata,
    output logic                    err_pulse,
    output logic                    warn_pulse,
    output logic [NDMA-1:0]         dma_rd_seen,
    output logic [NDMA-1:0]         dma_wr_seen
);
    route_t rt;

    io_rt_decode #(.DISK1_PRESENT(DISK1_PRESENT), .DMA_MASK(DMA_MASK)) u_dec (
        .off (req_offset),
        .rt  (rt)
    );

    assign req_ready  = 1'b1;
    assign port_sel   = (req_valid && rt.hit) ? (NPORT'(1) << rt.port) : '0;
    assign port_we    = req_valid && req_write && rt.hit;
    assign port_idx   = rt.idx;
    assign port_wdata = rt.swap ? swap_by_size(req_wdata, req_size) : req_wdata;

    io_rt_dma_flags u_flags (
        .clk     (clk),
        .rst     (rst),
        .rd_bad  (req_valid && !req_write && rt.dma_bad),
        .wr_bad  (req_valid && req_write && rt.dma_bad),
        .ch      (rt.dma_ch),
        .rd_seen (dma_rd_seen),
        .wr_seen (dma_wr_seen)
    );

    io_rt_resp u_resp (
        .clk        (clk),
        .rst        (rst),
        .fire       (req_valid),
        .is_write   (req_write),
        .size       (req_size),
        .rt         (rt),
        .port_rdata (port_rdata),
        .rsp_valid  (rsp_valid),
        .rsp_rdata  (rsp_rdata),
        .err_pulse  (err_pulse),
        .warn_pulse (warn_pulse)
    );
endmodule

// File: rtl/io_addr_router_chk.sv
module io_addr_router_chk import io_rt_pkg::*; (
    input logic              clk,
    input logic              rst,
    input logic              req_valid,
    input logic              req_write,
    input logic [NPORT-1:0]  port_sel,
    input logic              port_we,
    input logic              rsp_valid,
    input logic [DATA_W-1:0] rsp_rdata,
    input logic              err_pulse,
    input logic              warn_pulse,
    input logic [NDMA-1:0]   dma_rd_seen,
    input logic [NDMA-1:0]   dma_wr_seen
);
    // R1
    sel_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(port_sel) && (req_valid || port_sel == '0));
    // R1
    we_with_sel_chk: assert property (@(posedge clk) disable iff (rst)
        port_we |-> $onehot(port_sel));
    // R13
    rsp_follows_req_chk: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> rsp_valid);
    // R13
    rsp_needs_req_chk: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> $past(req_valid));
    // R13
    write_rsp_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && $past(req_write)) |-> rsp_rdata == '0);
    // R6
    gap_reads_zero_chk: assert property (@(posedge clk) disable iff (rst)
        err_pulse |-> (rsp_rdata == '0 && !warn_pulse));
    // R12
    stray_reads_zero_chk: assert property (@(posedge clk) disable iff (rst)
        warn_pulse |-> rsp_rdata == '0);
    // R4
    rd_flag_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (dma_rd_seen & $past(dma_rd_seen)) == $past(dma_rd_seen));
    // R4
    wr_flag_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (dma_wr_seen & $past(dma_wr_seen)) == $past(dma_wr_seen));
endmodule

bind io_addr_router io_addr_router_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .req_valid   (req_valid),
    .req_write   (req_write),
    .port_sel    (port_sel),
    .port_we     (port_we),
    .rsp_valid   (rsp_valid),
    .rsp_rdata   (rsp_rdata),
    .err_pulse   (err_pulse),
    .warn_pulse  (warn_pulse),
    .dma_rd_seen (dma_rd_seen),
    .dma_wr_seen (dma_wr_seen)
);

// File: tb/io_addr_router_tb.sv
module io_addr_router_tb;
    localparam int CLK_PERIOD = 10;
    localparam int NP = 10;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #(CLK_PERIOD/2) clk = ~clk;

    logic          req_valid = 1'b0, req_write = 1'b0;
    logic [18:0]   req_offset = '0;
    logic [1:0]    req_size = 2'd2;
    logic [31:0]   req_wdata = '0;
    logic          req_ready, rsp_valid, port_we, err_pulse, warn_pulse;
    logic [31:0]   rsp_rdata, port_wdata;
    logic [NP-1:0] port_sel;
    logic [14:0]   port_idx;
    logic [NP*32-1:0] port_rdata;
    logic [127:0]  dma_rd_seen, dma_wr_seen;

    logic          a_ready, a_rsp_valid, a_we, a_err, a_warn;
    logic [31:0]   a_rdata, a_wdata;
    logic [NP-1:0] a_sel;
    logic [14:0]   a_idx;
    logic [127:0]  a_rd_seen, a_wr_seen;

    io_addr_router u_dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_offset(req_offset), .req_size(req_size),
        .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .port_sel(port_sel), .port_we(port_we), .port_idx(port_idx),
        .port_wdata(port_wdata), .port_rdata(port_rdata), .err_pulse(err_pulse),
        .warn_pulse(warn_pulse), .dma_rd_seen(dma_rd_seen), .dma_wr_seen(dma_wr_seen));

    io_addr_router #(.DISK1_PRESENT(1'b0)) u_alt (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(a_ready),
        .req_write(req_write), .req_offset(req_offset), .req_size(req_size),
        .req_wdata(req_wdata), .rsp_valid(a_rsp_valid), .rsp_rdata(a_rdata),
        .port_sel(a_sel), .port_we(a_we), .port_idx(a_idx),
        .port_wdata(a_wdata), .port_rdata(port_rdata), .err_pulse(a_err),
        .warn_pulse(a_warn), .dma_rd_seen(a_rd_seen), .dma_wr_seen(a_wr_seen));

    function automatic logic [31:0] model(int p, logic [14:0] idx);
        return {4'hA, 4'(p), 9'h0, idx};
    endfunction

    function automatic logic [31:0] swp(logic [31:0] d, logic [1:0] sz);
        if (sz == 2'd0) return d;
        if (sz == 2'd1) return {16'h0, d[7:0], d[15:8]};
        return {d[7:0], d[15:8], d[23:16], d[31:24]};
    endfunction

    function automatic logic [18:0] off(logic [6:0] rg, logic [11:0] low);
        return {rg, low};
    endfunction

    always_comb begin
        for (int p = 0; p < NP; p++) port_rdata[p*32 +: 32] = model(p, port_idx);
    end

    typedef struct {
        logic [31:0] rd;
        logic [31:0] alt;
        logic        err;
        logic        warn;
        string       tag;
    } item_t;
    item_t sbq[$];

    int n_chk = 0, n_fail = 0;
    bit done = 1'b0;

    task automatic chk(bit ok, string tag, logic [127:0] act, logic [127:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic xfer(bit wr, logic [18:0] o, logic [1:0] sz, logic [31:0] wd,
                        int ep, logic [14:0] eidx, logic [31:0] ewd,
                        logic [31:0] erd, logic [31:0] ealt, bit ee, bit ew, string tag);
        item_t it;
        logic [NP-1:0] esel;
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_offset = o; req_size = sz; req_wdata = wd;
        #1;
        esel = (ep < 0) ? '0 : (NP'(1) << ep);
        chk(port_sel == esel, {tag, " sel"}, 128'(port_sel), 128'(esel));
        if (ep >= 0) chk(port_idx == eidx, {tag, " idx"}, 128'(port_idx), 128'(eidx));
        if (wr) chk(port_we == (ep >= 0), {tag, " we"}, 128'(port_we), 128'(ep >= 0));
        if (wr && ep >= 0) chk(port_wdata == ewd, {tag, " wdata"}, 128'(port_wdata), 128'(ewd));
        it.rd = wr ? 32'h0 : erd;
        it.alt = wr ? 32'h0 : ealt;
        it.err = ee; it.warn = ew; it.tag = tag;
        sbq.push_back(it);
        @(posedge clk);
        #1 req_valid = 1'b0;
    endtask

    task automatic rd(logic [18:0] o, int ep, logic [14:0] eidx, string tag);
        logic [31:0] v;
        v = (ep < 0) ? 32'h0 : model(ep, eidx);
        xfer(1'b0, o, 2'd2, 32'h0, ep, eidx, 32'h0, v, v, 1'b0, 1'b0, tag);
    endtask

    // monitor: pops the scoreboard as responses arrive
    always @(negedge clk) begin
        if (!rst && rsp_valid) begin
            if (sbq.size() == 0) begin
                chk(1'b0, "R13 unexpected rsp", 1, 0);
            end else begin
                item_t it;
                it = sbq.pop_front();
                chk(rsp_rdata == it.rd, {it.tag, " rdata"}, 128'(rsp_rdata), 128'(it.rd));
                chk(a_rdata == it.alt, {it.tag, " alt rdata"}, 128'(a_rdata), 128'(it.alt));
                chk(err_pulse == it.err, {it.tag, " err"}, 128'(err_pulse), 128'(it.err));
                chk(warn_pulse == it.warn, {it.tag, " warn"}, 128'(warn_pulse), 128'(it.warn));
            end
        end
    end

    int cyc = 0;
    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000 && !done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=%0d expected<20000", cyc);
            $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        logic [18:0] o;
        repeat (3) @(posedge clk);
        #1;
        chk(rsp_valid == 1'b0, "R13 reset rsp_valid", 128'(rsp_valid), 0);
        chk(req_ready == 1'b1, "R13 ready", 128'(req_ready), 1);
        @(negedge clk) rst = 1'b0;
        chk(dma_rd_seen == '0 && dma_wr_seen == '0, "R4 reset flags", dma_rd_seen | dma_wr_seen, 0);

        rd(off(7'h00, 12'h034), 0, 15'h34, "R1 ctrl");
        rd(off(7'h10, 12'h0A5), 2, 15'hA, "R1 scsi");
        rd(off(7'h13, 12'h070), 4, 15'h7, "R1 serial");
        rd(off(7'h15, 12'h030), 5, 15'h3, "R1 floppy");
        rd(off(7'h08, 12'h210), 1, 15'h0210, "R2 dma ch2");
        xfer(1'b1, off(7'h08, 12'h710), 2'd2, 32'hCAFE0001, 1, 15'h0710, 32'hCAFE0001,
             0, 0, 1'b0, 1'b0, "R2 dma ch7 write");
        rd(off(7'h08, 12'h420), -1, 0, "R3 dma ch4 read");
        chk(dma_rd_seen == (128'd1 << 4) && dma_wr_seen == '0, "R4 rd flag ch4", dma_rd_seen, 128'd1 << 4);
        xfer(1'b1, off(7'h08, 12'h404), 2'd2, 32'h1, -1, 0, 0, 0, 0, 1'b0, 1'b0, "R3 dma ch4 write");
        xfer(1'b1, off(7'h08, 12'h500), 2'd2, 32'h1, -1, 0, 0, 0, 0, 1'b0, 1'b0, "R3 dma ch5 write");
        rd(off(7'h08, 12'h420), -1, 0, "R3 dma ch4 reread");
        chk(dma_rd_seen == (128'd1 << 4), "R4 rd flags", dma_rd_seen, 128'd1 << 4);
        chk(dma_wr_seen == ((128'd1 << 4) | (128'd1 << 5)), "R4 wr flags", dma_wr_seen,
            (128'd1 << 4) | (128'd1 << 5));

        rd(off(7'h12, 12'h000), 4, 15'h1, "R5 legacy k0");
        rd(off(7'h12, 12'h006), 4, 15'h2, "R5 legacy k3");
        rd(off(7'h12, 12'h00A), 4, 15'h4, "R5 legacy k5");
        xfer(1'b0, off(7'h12, 12'h020), 2'd2, 0, -1, 0, 0, 0, 0, 1'b1, 1'b0, "R6 gap read");
        xfer(1'b1, off(7'h12, 12'h05F), 2'd2, 32'h55, -1, 0, 0, 0, 0, 1'b1, 1'b0, "R6 gap write");
        rd(off(7'h12, 12'h085), 4, 15'h8, "R7 legacy native");
        rd(off(7'h12, 12'h060), 4, 15'h6, "R7 legacy edge");

        rd(off(7'h16, 12'hA00), 6, 15'h5, "R8 via A");
        rd(off(7'h17, 12'h600), 6, 15'hB, "R8 via B");

        rd(off(7'h20, 12'hAB0), 7, 15'hAB, "R9 disk0");
        v = model(8, 15'h12);
        xfer(1'b0, off(7'h21, 12'h120), 2'd2, 0, 8, 15'h12, 0, v, 32'h0, 1'b0, 1'b0, "R9 disk1");
        chk(a_sel == '0, "R9 absent disk1 sel", 128'(a_sel), 0);

        v = model(3, 15'h234);
        xfer(1'b0, off(7'h11, 12'h234), 2'd2, 0, 3, 15'h234, 0, swp(v, 2'd2), swp(v, 2'd2),
             1'b0, 1'b0, "R10 enet word read");
        xfer(1'b0, off(7'h11, 12'h234), 2'd1, 0, 3, 15'h234, 0, swp(v, 2'd1), swp(v, 2'd1),
             1'b0, 1'b0, "R10 enet half read");
        xfer(1'b0, off(7'h11, 12'h234), 2'd0, 0, 3, 15'h234, 0, v, v, 1'b0, 1'b0, "R10 enet byte read");
        xfer(1'b1, off(7'h11, 12'h008), 2'd2, 32'h11223344, 3, 15'h8, 32'h44332211,
             0, 0, 1'b0, 1'b0, "R10 enet word write");
        xfer(1'b1, off(7'h11, 12'h008), 2'd1, 32'h11223344, 3, 15'h8, 32'h00004433,
             0, 0, 1'b0, 1'b0, "R10 enet half write");

        o = off(7'h65, 12'h5F0);
        rd(o, 9, 15'(o[16:4]), "R11 nvram");
        o = off(7'h7F, 12'hFF0);
        rd(o, 9, 15'(o[16:4]), "R11 nvram top");

        xfer(1'b0, off(7'h30, 12'h010), 2'd2, 0, -1, 0, 0, 0, 0, 1'b0, 1'b1, "R12 stray read");
        xfer(1'b1, off(7'h14, 12'h010), 2'd2, 32'h9, -1, 0, 0, 0, 0, 1'b0, 1'b1, "R12 stray write");
        xfer(1'b1, off(7'h13, 12'h040), 2'd2, 32'hBEEF, 4, 15'h4, 32'hBEEF, 0, 0, 1'b0, 1'b0,
             "R13 write response zero");

        repeat (3) @(negedge clk);
        chk(sbq.size() == 0, "R13 all responses", 128'(sbq.size()), 0);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end
endmodule